// File: doc/BRIEF.md
# MAC Event Interrupt Controller

This block collects seventeen single-cycle status pulses from a 10-gigabit Ethernet MAC. They cover management-interface (MDIO) activity, link faults, transmit and receive FIFO trouble, memory ECC errors and receive frame errors. Each pulse sets its own sticky bit in an event register. The bit stays set until software clears it by writing a one to it. A mask register decides which latched events may reach the interrupt lines.

The masked events are split across two registered, active-high interrupt lines. One line carries only the two MDIO bits. The other carries every fault and error bit. An error handler therefore never sees MDIO activity, and an MDIO poller never sees errors.

Software reaches both registers through a plain 32-bit port with a word address, a write strobe and a read strobe. Read data comes back one clock after the read strobe.

Top module: `mac_evt_intc`

## Requirements
- R1: While reset is held and right after it, the event register, both interrupt lines and the read data are zero, and the mask register holds 0x17FFB. This value enables every source except bit 15 (MDIO command done) and bit 2 (RX length error).
- R2: A one on input bit i in one cycle sets event bit i from the next clock on, and the bit stays set until it is cleared. The bit map is:
  - bit 16: MDIO scan
  - bit 15: MDIO command done
  - bit 14: remote fault
  - bit 13: local fault
  - bit 12: TX ECC
  - bit 11: TX FIFO underflow
  - bit 10: TX FIFO overflow
  - bit 9: TX error
  - bit 8: RX FIFO overflow
  - bit 7: RX ECC
  - bit 6: jabber
  - bit 5: oversize
  - bit 4: runt
  - bit 3: fragment
  - bit 2: length error
  - bit 1: CRC error
  - bit 0: alignment error
- R3: A write to word address 1 clears each event bit whose write-data bit is one and leaves every other event bit unchanged. Writing all ones clears every pending event.
- R4: When a pulse and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R5: A write to word address 0 replaces the mask with write-data bits 16:0. A cleared mask bit keeps its event off both interrupt lines, while the event itself still latches.
- R6: The MDIO interrupt line equals the OR of (event AND mask) over bits 16 and 15, as held in the registers one clock earlier.
- R7: The error interrupt line equals the OR of (event AND mask) over bits 14 down to 0, as held in the registers one clock earlier. Bits 16 and 15 never affect it.
- R8: Bits 31 to 17 of both registers read as zero, and writes to them have no effect.
- R9: A read strobe at word address 0 or 1 returns the register value held at that clock edge on the read data output during the following cycle. In any cycle that follows no read strobe, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 17 | Single-cycle event pulses, bit map as in R2 |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 1 | Word address: 0 mask, 1 event |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_mdio | output | 1 | MDIO interrupt, active high |
| irq_err | output | 1 | Fault and error interrupt, active high |

## Verification
The bench drives a pulse into a bit in the same cycle as a write that clears it. A design that lets the clear win would lose that event. The bench latches the MDIO command-done event under the reset mask and then opens the mask. A design that routes the MDIO bits into the error line, or that ignores the mask, raises the wrong interrupt. Partial clears check that a zero in the write data leaves its event bit untouched. Reads after all-ones writes catch upper bits that fail to read back as zero. A long random run against a behavioural model compares the two interrupt lines and the read data on every cycle. That run exposes any extra or missing register stage on either path.

// File: rtl/mac_evt_pkg.sv
package mac_evt_pkg;
   localparam int EVT_NUM      = 17;
   localparam int MDIO_NUM     = 2;
   localparam int WORD_W       = 32;
   localparam int WADDR_W      = 1;
   localparam int OFS_MASK     = 0;
   localparam int OFS_EVENT    = 1;
   localparam logic [EVT_NUM-1:0] MASK_AT_RESET = 17'h17FFB;
endpackage

// File: rtl/mac_evt_bank.sv
module mac_evt_bank #(
   parameter int N = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] evt_o
);
   if (N < 1) begin : g_bad_n
      $error("mac_evt_bank: N must be positive");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic flag_q;
      always_ff @(posedge clk) begin
         if (!rst_n)         flag_q <= 1'b0;
         else if (set_i[i])  flag_q <= 1'b1;
         else if (clr_i[i])  flag_q <= 1'b0;
      end
      assign evt_o[i] = flag_q;

      p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_o[i] && !clr_i[i]) |=> evt_o[i]);
      p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> evt_o[i]);
      p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !evt_o[i]);
   end
endmodule

// File: rtl/mac_evt_mask.sv
module mac_evt_mask #(
   parameter int N = 17,
   parameter logic [N-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] mask_o
);
   logic [N-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    mask_q <= RST_VAL;
      else if (wr_i) mask_q <= wdata_i;
   end
   assign mask_o = mask_q;

   p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (mask_o == $past(wdata_i)));
   p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/mac_evt_irq.sv
module mac_evt_irq #(
   parameter int N       = 17,
   parameter int MDIO_N  = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] mask_i,
   output logic         irq_mdio_o,
   output logic         irq_err_o
);
   localparam logic [N-1:0] MDIO_SEL = {{MDIO_N{1'b1}}, {(N-MDIO_N){1'b0}}};
   localparam logic [N-1:0] ERR_SEL  = ~MDIO_SEL;

   if (MDIO_N < 1 || MDIO_N >= N) begin : g_bad_split
      $error("mac_evt_irq: MDIO_N must lie in 1..N-1");
   end

   logic [N-1:0] live;
   logic         mdio_any;
   logic         err_any;

   assign live     = evt_i & mask_i;
   assign mdio_any = |(live & MDIO_SEL);
   assign err_any  = |(live & ERR_SEL);

   if (IRQ_REG) begin : g_flop
      logic mdio_q, err_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mdio_q <= 1'b0;
            err_q  <= 1'b0;
         end else begin
            mdio_q <= mdio_any;
            err_q  <= err_any;
         end
      end
      assign irq_mdio_o = mdio_q;
      assign irq_err_o  = err_q;

      p_mdio_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (|(evt_i & mask_i & MDIO_SEL)) |=> irq_mdio_o);
      p_mdio_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(evt_i & mask_i & MDIO_SEL)) |=> !irq_mdio_o);
      p_err_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (|(evt_i & mask_i & ERR_SEL)) |=> irq_err_o);
      p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(evt_i & mask_i & ERR_SEL)) |=> !irq_err_o);
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_mdio_o = mdio_any;
      assign irq_err_o  = err_any;
   end
endmodule

// File: rtl/mac_evt_regport.sv
module mac_evt_regport #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 1,
   parameter int N        = 17,
   parameter int A_MASK   = 0,
   parameter int A_EVENT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [N-1:0]      mask_i,
   input  logic [N-1:0]      evt_i,
   output logic              mask_wr_o,
   output logic [N-1:0]      field_o,
   output logic [N-1:0]      evt_clr_o,
   output logic [DATA_W-1:0] rdata_o
);
   if (N > DATA_W) begin : g_bad_width
      $error("mac_evt_regport: N exceeds DATA_W");
   end
   if (A_MASK == A_EVENT) begin : g_bad_map
      $error("mac_evt_regport: register offsets collide");
   end

   logic hit_mask, hit_evt;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   assign hit_mask = (addr_i == ADDR_W'(A_MASK));
   assign hit_evt  = (addr_i == ADDR_W'(A_EVENT));

   assign field_o   = wdata_i[N-1:0];
   assign mask_wr_o = wr_en_i && hit_mask;
   assign evt_clr_o = (wr_en_i && hit_evt) ? wdata_i[N-1:0] : '0;

   if (N < DATA_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:N];
   end

   always_comb begin
      rd_mux = '0;
      if (hit_mask)     rd_mux = DATA_W'(mask_i);
      else if (hit_evt) rd_mux = DATA_W'(evt_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rdata_q <= '0;
      else if (rd_en_i) rdata_q <= rd_mux;
      else              rdata_q <= '0;
   end
   assign rdata_o = rdata_q;

   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> (rdata_o == '0));
   if (N < DATA_W) begin : g_hi_chk
      p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         rdata_o[DATA_W-1:N] == '0);
   end
endmodule

// File: rtl/mac_evt_intc.sv
module mac_evt_intc
   import mac_evt_pkg::*;
#(
   parameter int N       = EVT_NUM,
   parameter int MDIO_N  = MDIO_NUM,
   parameter int DATA_W  = WORD_W,
   parameter int ADDR_W  = WADDR_W,
   parameter bit IRQ_REG = 1'b1,
   parameter logic [N-1:0] MASK_RST = MASK_AT_RESET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      evt_pulse,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_mdio,
   output logic              irq_err
);
   logic [N-1:0] evt_q, mask_q, clr_v, field_v;
   logic         mask_wr;

   mac_evt_regport #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N(N),
      .A_MASK(OFS_MASK), .A_EVENT(OFS_EVENT)
   ) u_port (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(reg_wr_en), .rd_en_i(reg_rd_en),
      .addr_i(reg_addr), .wdata_i(reg_wdata),
      .mask_i(mask_q), .evt_i(evt_q),
      .mask_wr_o(mask_wr), .field_o(field_v),
      .evt_clr_o(clr_v), .rdata_o(reg_rdata)
   );

   mac_evt_bank #(.N(N)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_i(evt_pulse), .clr_i(clr_v), .evt_o(evt_q)
   );

   mac_evt_mask #(.N(N), .RST_VAL(MASK_RST)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .wr_i(mask_wr), .wdata_i(field_v), .mask_o(mask_q)
   );

   mac_evt_irq #(.N(N), .MDIO_N(MDIO_N), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .evt_i(evt_q), .mask_i(mask_q),
      .irq_mdio_o(irq_mdio), .irq_err_o(irq_err)
   );

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (evt_q == '0 && mask_q == MASK_RST && reg_rdata == '0));
endmodule

// File: tb/mac_evt_intc_test.sv
module mac_evt_intc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [16:0] evt_pulse = '0;
   logic        reg_wr_en = 1'b0;
   logic        reg_rd_en = 1'b0;
   logic [0:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_mdio, irq_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference state
   logic [16:0] m_evt, m_mask;
   logic [31:0] m_rdata;
   logic        m_irqm, m_irqe;

   always #10 clk = ~clk;

   mac_evt_intc uut (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_mdio(irq_mdio), .irq_err(irq_err)
   );

   always @(posedge clk) begin
      logic [16:0] live;
      logic [31:0] rv;
      if (!rst_n) begin
         m_evt = '0; m_mask = 17'h17FFB; m_rdata = '0; m_irqm = 0; m_irqe = 0;
      end else begin
         live   = m_evt & m_mask;
         m_irqm = live[16] | live[15];
         m_irqe = |live[14:0];
         rv = (reg_addr == 1'b0) ? {15'd0, m_mask} : {15'd0, m_evt};
         m_rdata = reg_rd_en ? rv : 32'd0;
         if (reg_wr_en && reg_addr == 1'b1) m_evt = m_evt & ~reg_wdata[16:0];
         if (reg_wr_en && reg_addr == 1'b0) m_mask = reg_wdata[16:0];
         m_evt = m_evt | evt_pulse;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      chk("R9 rdata vs model", reg_rdata, m_rdata);
      chk("R6 irq_mdio vs model", {31'd0, irq_mdio}, {31'd0, m_irqm});
      chk("R7 irq_err vs model", {31'd0, irq_err}, {31'd0, m_irqe});
   endtask

   task automatic rd(input logic a, output logic [31:0] d);
      reg_rd_en = 1'b1; reg_addr = a;
      tick();
      d = reg_rdata;
      reg_rd_en = 1'b0;
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [16:0] v);
      evt_pulse = v;
      tick();
      evt_pulse = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      chk("R1 rdata in reset", reg_rdata, 32'd0);
      chk("R1 irq lines in reset", {30'd0, irq_mdio, irq_err}, 32'd0);
      rst_n = 1'b1;
      tick();
      rd(1'b0, d); chk("R1 reset mask", d, 32'h0001_7FFB);
      rd(1'b1, d); chk("R1 reset events", d, 32'd0);

      // R2: sticky latch of alignment error (bit 0)
      pulse(17'h00001);
      tick();
      chk("R7 irq_err after bit0", {31'd0, irq_err}, 32'd1);
      repeat (3) tick();
      rd(1'b1, d); chk("R2 bit0 sticky", d, 32'h1);

      // R3: partial and full clear
      pulse(17'h00006);
      wr(1'b1, 32'h0000_0002);
      rd(1'b1, d); chk("R3 partial clear keeps others", d, 32'h5);
      wr(1'b1, 32'hFFFF_FFFF);
      rd(1'b1, d); chk("R3 clear all", d, 32'h0);
      tick();
      chk("R7 irq_err drops after clear", {31'd0, irq_err}, 32'd0);

      // R6/R7: MDIO command done masked at reset, never on error line
      pulse(17'h08000);
      tick();
      chk("R6 masked cmd-done no irq", {31'd0, irq_mdio}, 32'd0);
      chk("R7 mdio bit not on err line", {31'd0, irq_err}, 32'd0);
      rd(1'b1, d); chk("R2 cmd-done latched at bit 15", d, 32'h8000);
      wr(1'b0, 32'hFFFF_FFFF);
      tick();
      chk("R6 irq_mdio after unmask", {31'd0, irq_mdio}, 32'd1);
      chk("R7 err stays low with mdio only", {31'd0, irq_err}, 32'd0);
      rd(1'b0, d); chk("R8 mask upper bits zero", d, 32'h0001_FFFF);
      wr(1'b1, 32'hFFFF_FFFF);

      // R4: set and clear collide on bit 5
      pulse(17'h00020);
      evt_pulse = 17'h00020;
      wr(1'b1, 32'h0000_0020);
      evt_pulse = '0;
      rd(1'b1, d); chk("R4 pulse beats clear", d, 32'h20);

      // R5: mask all off, events latch but no irq
      wr(1'b0, 32'h0);
      pulse(17'h1_0010);
      repeat (2) tick();
      chk("R5 masked irq_mdio", {31'd0, irq_mdio}, 32'd0);
      chk("R5 masked irq_err", {31'd0, irq_err}, 32'd0);
      rd(1'b1, d); chk("R5 events still latch", d, 32'h1_0030);
      wr(1'b1, 32'hFFFE_0000);
      rd(1'b1, d); chk("R8 upper-bit write ignored", d, 32'h1_0030);
      wr(1'b0, 32'h0001_0000);
      tick();
      chk("R6 scan bit unmasked", {31'd0, irq_mdio}, 32'd1);

      // random phase against the model
      for (int k = 0; k < 3000; k++) begin
         evt_pulse = 17'($urandom & $urandom & $urandom);
         reg_wr_en = ($urandom % 5) == 0;
         reg_rd_en = ($urandom % 3) == 0;
         reg_addr  = 1'($urandom);
         reg_wdata = $urandom;
         tick();
      end
      evt_pulse = '0; reg_wr_en = 0; reg_rd_en = 0;
      tick();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule